// File: doc/BRIEF.md
# Programmable Binary Timer Divider

This block is a clocked timer built around a sixteen-stage binary counter. A single-cycle enable input, `tick_i`, stands in for the count clock: each cycle in which it is high advances the counter. Two select bits pick one of four division ratios (2^8, 2^10, 2^13 or 2^16). The chosen counter stage drives a single registered output, `tmr_o`.

The block has two operating modes. In recycle mode the selected stage drives the output continuously, which turns the block into a free-running 2^n frequency divider. In single-cycle mode the output changes state exactly once, half a selected period after the counter is cleared, and then holds that level. Another run can only start after a master reset or a change of the mode level.

A polarity input sets the output level while the counter is cleared and inverts the output in both modes. A power-on reset input takes effect only while automatic reset is enabled. The master reset acts whatever the automatic-reset setting is.

Top module: `prog_timer_div`

## Requirements
- R1: While any clear condition is present in a cycle, the counter and the single-cycle latch are zeroed at that clock edge, and on the same edge `tmr_o` takes the value of `inv_i`.
- R2: `por_i` clears the block only while `auto_off_i` is 0. While `auto_off_i` is 1, `por_i` has no effect and counting carries on.
- R3: `mrst_i` = 1 clears the block whatever the value of `auto_off_i`.
- R4: The counter changes only at an edge where `tick_i` is 1. Outside the bypass setting it advances by one at each such edge.
- R5: The select input {`sel_a_i`,`sel_b_i`} picks counter stage n as follows: 00 gives n=13, 01 gives n=10, 11 gives n=16, 10 gives n=16 with bypass. Stage n is counter bit n-1, so its period is 2^n ticks.
- R6: With {`sel_a_i`,`sel_b_i`} = 10, each tick advances counter bits 15..8 by one and leaves bits 7..0 unchanged. The output period is then 256 ticks.
- R7: With `recycle_i` = 1, `tmr_o` equals the selected stage bit XOR `inv_i`.
- R8: With `recycle_i` = 0, `tmr_o` equals `inv_i` until 2^(n-1) ticks have been counted since the last clear. It then equals NOT `inv_i` and holds there through all later ticks until the next clear.
- R9: A change of the `recycle_i` level, seen against its value in the previous cycle, clears the counter and the latch just as a reset does.
- R10: `tmr_o` is a register. It reflects the counter state one clock after the edge at which the counter reached that state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; all state changes on its rising edge |
| tick_i | input | 1 | Count enable, one pulse per count |
| mrst_i | input | 1 | Master reset, active high, synchronous |
| por_i | input | 1 | Power-on reset event, active high, synchronous |
| auto_off_i | input | 1 | 1 disables the power-on reset |
| sel_a_i | input | 1 | Division select, upper bit |
| sel_b_i | input | 1 | Division select, lower bit |
| recycle_i | input | 1 | 1 = recycle mode, 0 = single-cycle mode |
| inv_i | input | 1 | Output polarity; output level while cleared |
| tmr_o | output | 1 | Timer output |

## Verification
The bench targets the following corner cases, and for each one states how a faulty design would give itself away:

- **Bypass setting.** A design that still ripples through the low eight stages would stretch the output period from 256 ticks to 65536 ticks.
- **Single-cycle latch.** Two faults are watched past a full selected period. A latch that fails to hold would let the output toggle again on the second half-period. A latch that sets one count early or late would move the single transition.
- **Power-on reset with automatic reset disabled.** A design that ignores the gating would restart the count when it should not.
- **Mode flips in the middle of a run.** A design without the edge detector would leave a fired single-cycle run stuck and never re-arm it.
- **Random stimulus.** Randomly timed ticks, resets and polarity changes expose any off-by-one error in the output register latency.

// File: rtl/prog_timer_pkg.sv
package prog_timer_pkg;

  // Division select code, {sel_a, sel_b}
  typedef enum logic [1:0] {
    DIV_MID = 2'b00,
    DIV_LOW = 2'b01,
    DIV_BYP = 2'b10,
    DIV_TOP = 2'b11
  } div_sel_e;

  function automatic div_sel_e pack_sel(input logic a, input logic b);
    return div_sel_e'({a, b});
  endfunction

  function automatic logic is_bypass(input div_sel_e sel);
    return sel == DIV_BYP;
  endfunction

  // Stage number n for a select code, given the configured stage numbers
  function automatic int unsigned stage_num(input div_sel_e sel,
                                            input int unsigned n_mid,
                                            input int unsigned n_low,
                                            input int unsigned n_top);
    case (sel)
      DIV_MID: return n_mid;
      DIV_LOW: return n_low;
      default: return n_top;
    endcase
  endfunction

endpackage

// File: rtl/tmr_reset_ctl.sv
module tmr_reset_ctl (
  input  logic clk_i,
  input  logic mrst_i,
  input  logic por_i,
  input  logic auto_off_i,
  input  logic recycle_i,
  output logic hard_rst_o,
  output logic mode_chg_o,
  output logic clear_o
);
  logic mode_q;

  always_ff @(posedge clk_i) begin
    mode_q <= recycle_i;
  end

  assign hard_rst_o = por_i & ~auto_off_i;
  assign mode_chg_o = ~hard_rst_o & (mode_q != recycle_i);
  assign clear_o    = hard_rst_o | mrst_i | mode_chg_o;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYP_LO = 8
) (
  input  logic             clk_i,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic             bypass_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] STEP_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] STEP_BYP = CNT_W'(1) << BYP_LO;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] step_w;

  assign step_w = bypass_i ? STEP_BYP : STEP_ONE;

  always_ff @(posedge clk_i) begin
    if (clear_i)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + step_w;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_stage_sel.sv
module tmr_stage_sel
  import prog_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_MID = 13,
  parameter int unsigned N_LOW = 10,
  parameter int unsigned N_TOP = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  div_sel_e         sel_i,
  output logic             stage_o,
  output logic             bypass_o
);
  localparam int unsigned IX_MID = N_MID - 1;
  localparam int unsigned IX_LOW = N_LOW - 1;
  localparam int unsigned IX_TOP = N_TOP - 1;

  logic [3:0] taps_w;

  // One tap per select code; codes 10 and 11 share the top stage
  for (genvar g = 0; g < 4; g++) begin : g_tap
    localparam int unsigned IX =
      stage_num(div_sel_e'(g), N_MID, N_LOW, N_TOP) - 1;
    assign taps_w[g] = cnt_i[IX];
  end

  assign stage_o  = taps_w[sel_i];
  assign bypass_o = is_bypass(sel_i);
endmodule

// File: rtl/tmr_out_ctl.sv
module tmr_out_ctl (
  input  logic clk_i,
  input  logic clear_i,
  input  logic stage_i,
  input  logic recycle_i,
  input  logic inv_i,
  output logic latch_o,
  output logic out_o
);
  logic latch_q;
  logic out_q;
  logic level_w;

  assign level_w = recycle_i ? stage_i : (latch_q | stage_i);

  always_ff @(posedge clk_i) begin
    if (clear_i) begin
      latch_q <= 1'b0;
      out_q   <= inv_i;
    end else begin
      latch_q <= latch_q | stage_i;
      out_q   <= level_w ^ inv_i;
    end
  end

  assign latch_o = latch_q;
  assign out_o   = out_q;
endmodule

// File: rtl/prog_timer_div.sv
module prog_timer_div
  import prog_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYP_LO = 8,
  parameter int unsigned N_MID  = 13,
  parameter int unsigned N_LOW  = 10
) (
  input  logic clk_i,
  input  logic tick_i,
  input  logic mrst_i,
  input  logic por_i,
  input  logic auto_off_i,
  input  logic sel_a_i,
  input  logic sel_b_i,
  input  logic recycle_i,
  input  logic inv_i,
  output logic tmr_o
);
  localparam int unsigned N_TOP = CNT_W;

  logic             hard_rst_w;
  logic             mode_chg_w;
  logic             clear_w;
  logic             bypass_w;
  logic             stage_w;
  logic             latch_w;
  logic [CNT_W-1:0] cnt_w;
  div_sel_e         sel_w;

  assign sel_w = pack_sel(sel_a_i, sel_b_i);

  tmr_reset_ctl u_rst (
    .clk_i      (clk_i),
    .mrst_i     (mrst_i),
    .por_i      (por_i),
    .auto_off_i (auto_off_i),
    .recycle_i  (recycle_i),
    .hard_rst_o (hard_rst_w),
    .mode_chg_o (mode_chg_w),
    .clear_o    (clear_w)
  );

  tmr_counter #(.CNT_W(CNT_W), .BYP_LO(BYP_LO)) u_cnt (
    .clk_i    (clk_i),
    .clear_i  (clear_w),
    .tick_i   (tick_i),
    .bypass_i (bypass_w),
    .cnt_o    (cnt_w)
  );

  tmr_stage_sel #(.CNT_W(CNT_W), .N_MID(N_MID), .N_LOW(N_LOW), .N_TOP(N_TOP)) u_sel (
    .cnt_i    (cnt_w),
    .sel_i    (sel_w),
    .stage_o  (stage_w),
    .bypass_o (bypass_w)
  );

  tmr_out_ctl u_out (
    .clk_i     (clk_i),
    .clear_i   (clear_w),
    .stage_i   (stage_w),
    .recycle_i (recycle_i),
    .inv_i     (inv_i),
    .latch_o   (latch_w),
    .out_o     (tmr_o)
  );
endmodule

// File: rtl/prog_timer_div_chk.sv
module prog_timer_div_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYP_LO = 8
) (
  input logic             clk_i,
  input logic             hard_rst,
  input logic             clear,
  input logic             mrst,
  input logic             por,
  input logic             auto_off,
  input logic             mode_chg,
  input logic             tick,
  input logic             bypass,
  input logic             stage,
  input logic             latch,
  input logic             recycle,
  input logic             inv,
  input logic [CNT_W-1:0] cnt,
  input logic             tmr
);
  AST_CLEAR_OUT: assert property (@(posedge clk_i) disable iff (hard_rst)
    clear |=> (tmr == $past(inv)));                                  // R1
  AST_POR_IGNORED: assert property (@(posedge clk_i) disable iff (hard_rst)
    (por && auto_off && !mrst && !mode_chg && tick && !bypass)
      |=> (cnt == $past(cnt) + 1'b1));                               // R2
  AST_MRST_CLEARS: assert property (@(posedge clk_i) disable iff (hard_rst)
    mrst |=> (cnt == '0 && !latch));                                 // R3
  AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (hard_rst)
    (!clear && !tick) |=> $stable(cnt));                             // R4
  AST_BYPASS_LOW: assert property (@(posedge clk_i) disable iff (hard_rst)
    (!clear && bypass) |=> (cnt[BYP_LO-1:0] == $past(cnt[BYP_LO-1:0]))); // R6
  AST_RECYCLE_OUT: assert property (@(posedge clk_i) disable iff (hard_rst)
    (!clear && recycle) |=> (tmr == $past(stage ^ inv)));            // R7
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (hard_rst)
    (!clear && latch) |=> latch);                                    // R8
  AST_SINGLE_HOLD: assert property (@(posedge clk_i) disable iff (hard_rst)
    (!clear && !recycle && latch) |=> (tmr == !$past(inv)));         // R8
  AST_MODE_REARM: assert property (@(posedge clk_i) disable iff (hard_rst)
    mode_chg |=> (cnt == '0 && !latch));                             // R9
endmodule

bind prog_timer_div prog_timer_div_chk #(.CNT_W(CNT_W), .BYP_LO(BYP_LO)) chk_i (
  .clk_i    (clk_i),
  .hard_rst (hard_rst_w),
  .clear    (clear_w),
  .mrst     (mrst_i),
  .por      (por_i),
  .auto_off (auto_off_i),
  .mode_chg (mode_chg_w),
  .tick     (tick_i),
  .bypass   (bypass_w),
  .stage    (stage_w),
  .latch    (latch_w),
  .recycle  (recycle_i),
  .inv      (inv_i),
  .cnt      (cnt_w),
  .tmr      (tmr_o)
);

// File: tb/prog_timer_div_tb_top.sv
module prog_timer_div_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic tick = 1'b0, mrst = 1'b0, por = 1'b1, aoff = 1'b0;
  logic sa = 1'b0, sb = 1'b0, rec = 1'b0, inv = 1'b0;
  logic tmr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // Reference model state
  int unsigned m_ticks = 0;   // ticks seen on the selected stage's time base
  bit m_fired = 1'b0;
  bit m_mode  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_timer_div dut_i (
    .clk_i(clk), .tick_i(tick), .mrst_i(mrst), .por_i(por),
    .auto_off_i(aoff), .sel_a_i(sa), .sel_b_i(sb),
    .recycle_i(rec), .inv_i(inv), .tmr_o(tmr)
  );

  // Stage number n for select bits (R5)
  function automatic int stage_n(input bit a, input bit b);
    if (a) return 16;
    return b ? 10 : 13;
  endfunction

  // Stage level: counter value as a count of 2^(16-n')... expressed via period
  function automatic bit stage_lvl(input int unsigned cnt16, input bit a, input bit b);
    int n = stage_n(a, b);
    return ((cnt16 % (1 << n)) >= (1 << (n - 1)));
  endfunction

  task automatic check(input bit exp, input string tag);
    n_tests++;
    if (tmr !== exp) begin
      n_fail++;
      $display("FAIL %s: tmr_o actual=%b expected=%b at %0t", tag, tmr, exp, $time);
    end
  endtask

  // Apply one cycle of inputs, update the model, compare after the edge
  task automatic step(input bit t, input bit mr, input bit pr, input bit ao,
                      input bit a, input bit b, input bit rc, input bit iv,
                      input string tag);
    bit clr, exp, lvl;
    tick = t; mrst = mr; por = pr; aoff = ao; sa = a; sb = b; rec = rc; inv = iv;
    @(posedge clk);
    #1;
    clr = mr || (pr && !ao) || (m_mode != rc);
    lvl = stage_lvl(m_ticks, a, b);
    if (clr) exp = iv;                              // R1
    else if (rc) exp = lvl ^ iv;                    // R7
    else exp = (m_fired || lvl) ^ iv;               // R8
    if (clr) begin
      m_ticks = 0; m_fired = 1'b0;
    end else begin
      m_fired = m_fired || lvl;
      if (t) m_ticks = (m_ticks + ((a && !b) ? 256 : 1)) & 32'hFFFF; // R4 R6
    end
    m_mode = rc;
    check(exp, tag);
  endtask

  task automatic run(input int cycles, input bit a, input bit b, input bit rc,
                     input bit iv, input string tag);
    for (int i = 0; i < cycles; i++) step(1'b1, 1'b0, 1'b0, 1'b0, a, b, rc, iv, tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1 reset state, both polarities
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R1");
    // R8 single cycle with 2^10 (sel 01): fires at 512, holds past 2048
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
    run(2100, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
    // R9 mode flip re-arms, then a second run with inverted polarity
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R9");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R9");
    run(1200, 1'b0, 1'b1, 1'b0, 1'b1, "R9");
    // R6 bypass recycle, period 256 ticks
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R3");
    run(700, 1'b1, 1'b0, 1'b1, 1'b0, "R6");
    // R5 R7 recycle with 2^13 (sel 00)
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R3");
    run(17000, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
    // R2 power-on reset ignored while auto reset is off
    for (int i = 0; i < 50; i++) step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R2");
    // R8 R10 single cycle with 2^16 (sel 11), fires at 32768
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R3");
    run(33000, 1'b1, 1'b1, 1'b0, 1'b0, "R10");
    // Random phase
    for (int i = 0; i < 20000; i++) begin
      bit t, mr, pr, ao, a, b, rc, iv;
      t  = ($urandom % 4) != 0;
      mr = ($urandom % 400) == 0;
      pr = ($urandom % 300) == 0;
      ao = ($urandom % 2) == 0;
      a  = (i / 2500) % 2 == 1;
      b  = (i / 5000) % 2 == 1;
      rc = (($urandom % 1500) == 0) ? !rec : rec;
      iv = (($urandom % 700) == 0) ? !inv : inv;
      step(t, mr, pr, ao, a, b, rc, iv, "R4");
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule